// File: doc/BRIEF.md
# Control Endpoint Status Register

This block holds the control and status word for endpoint zero, the control endpoint of a USB device controller. Two sides act on it. The packet engine reports bus events as single-cycle pulses: an OUT packet arrived, an IN packet went out, a control OUT was seen, a stall handshake was sent, and a setup transaction began. The processor reads and writes the word through a plain 32-bit register port. Each field has its own access rule. Some fields are set by hardware and cleared when software writes a one. Some are set by software and read back as zero. The rest are read-only views of status inputs.

The block sends a small set of controls back to the packet engine. The first is a hold that blocks the data phase while received data waits for software. The second is a level that arms a short IN packet. The third is a one-cycle transmit-FIFO flush strobe. The fourth is a forced-stall level. The block also raises a one-cycle endpoint interrupt request when the interrupt mask allows it. A clear of the IN-armed state caused by a flush is silent. A clear caused by a finished transfer or by a control OUT raises the interrupt.

Top module: `ep0_ctrl_csr`

## Requirements
- R1: After synchronous reset, every bit of `reg_rdata` reads zero when both status inputs are low. `in_pkt_rdy`, `data_hold`, `stall_force`, `flush_strobe` and `irq_ep0` are all low. Bits 31:8 always read zero, whatever value is written to them.
- R2: Bit 0 (OUT waiting) is set by a pulse on `ev_out_rcvd`. A write with bit 0 at one clears it. If the event and the clearing write fall in the same cycle, the bit ends up set.
- R3: `data_hold` is high in every cycle in which bit 0 is set, and low otherwise.
- R4: A write with bit 1 at one arms the IN packet, and `in_pkt_rdy` goes high on the next cycle. Bit 1 always reads zero. A write with bit 1 at zero leaves `in_pkt_rdy` unchanged.
- R5: `in_pkt_rdy` is cleared by `ev_in_sent`, by `ev_ctrl_out`, or by a write with bit 2 at one. A write that sets bit 1 in the same cycle as `ev_in_sent` or `ev_ctrl_out` leaves it armed. A write that sets both bit 1 and bit 2 leaves it cleared.
- R6: When `irq_mask` is high, `irq_ep0` is a one-cycle pulse in the cycle after either of two events. One is `ev_out_rcvd`. The other is `ev_in_sent` or `ev_ctrl_out` arriving while `in_pkt_rdy` is high.
- R7: `irq_ep0` stays low when `in_pkt_rdy` is cleared only by a flush write, and it stays low whenever `irq_mask` is low.
- R8: A write with bit 2 at one makes `flush_strobe` high for exactly the next cycle. Bit 2 always reads zero.
- R9: Bit 4 (stall sent) is set by `ev_stall_sent` and cleared by a write with bit 4 at one. The event wins if both fall in the same cycle.
- R10: Bit 5 (force stall) is set by a write with bit 5 at one, and it drives `stall_force`. It is cleared by `ev_stall_sent`. The write wins if both fall in the same cycle.
- R11: Bit 7 (setup active) is set by `ev_setup` and cleared by a write with bit 7 at one. The event wins if both fall in the same cycle.
- R12: Bit 3 follows `st_wakeup_en` and bit 6 follows `st_rx_nempty` in the same cycle. Writes to bits 3 and 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ev_out_rcvd | input | 1 | Valid OUT packet received for endpoint zero |
| ev_in_sent | input | 1 | IN packet transmitted successfully |
| ev_ctrl_out | input | 1 | Control OUT received |
| ev_stall_sent | input | 1 | Stall handshake sent |
| ev_setup | input | 1 | Setup transaction seen |
| st_wakeup_en | input | 1 | Remote wakeup enabled status |
| st_rx_nempty | input | 1 | Receive FIFO not empty status |
| irq_mask | input | 1 | Endpoint zero interrupt enable |
| irq_ep0 | output | 1 | Endpoint zero interrupt request pulse |
| data_hold | output | 1 | Blocks the data phase while OUT data waits |
| in_pkt_rdy | output | 1 | Short IN packet armed |
| flush_strobe | output | 1 | One-cycle transmit FIFO flush |
| stall_force | output | 1 | Force stall handshakes |

## Verification
The bench targets cycles in which a hardware event and a software write hit the same bit. A design that let the write win would lose a received packet, a stall report or a setup. The bench also checks that a flush clears the armed IN packet without an interrupt. A design that treated every clear alike would either interrupt on a flush or miss the interrupt for a finished transfer. It checks that an arm write landing with a transfer-done event keeps the new packet armed. It also checks that the write-one-to-set bits read zero and that writes to reserved and read-only bits are ignored. A design that got these wrong would arm or flush packets by accident or report false status.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;

    // Bit positions inside the register word; software decodes these.
    localparam int unsigned OPR_B    = 0;
    localparam int unsigned IPR_B    = 1;
    localparam int unsigned FTF_B    = 2;
    localparam int unsigned WAKE_B   = 3;
    localparam int unsigned SST_B    = 4;
    localparam int unsigned FST_B    = 5;
    localparam int unsigned RXNE_B   = 6;
    localparam int unsigned SA_B     = 7;
    localparam int unsigned ACTIVE_W = 8;

    // Indices of the held state bits.
    localparam int unsigned SL_OUT   = 0;
    localparam int unsigned SL_IN    = 1;
    localparam int unsigned SL_SST   = 2;
    localparam int unsigned SL_FST   = 3;
    localparam int unsigned SL_SA    = 4;
    localparam int unsigned N_STICKY = 5;

    // Software actions decoded from one write.
    typedef struct packed {
        logic opr_clr;
        logic ipr_set;
        logic flush;
        logic sst_clr;
        logic fst_set;
        logic sa_clr;
    } sw_cmd_t;

    // Hardware event pulses from the packet engine.
    typedef struct packed {
        logic out_rcvd;
        logic in_sent;
        logic ctrl_out;
        logic stall_sent;
        logic setup;
    } hw_evt_t;

    // Visible low byte of the register, most significant field first.
    typedef struct packed {
        logic sa;
        logic rxne;
        logic fst;
        logic sst;
        logic wake;
        logic ftf;
        logic ipr;
        logic opr;
    } csr_view_t;

    function automatic sw_cmd_t decode_write(input logic we,
                                             input logic [ACTIVE_W-1:0] wd);
        sw_cmd_t c;
        c.opr_clr = we & wd[OPR_B];
        c.ipr_set = we & wd[IPR_B];
        c.flush   = we & wd[FTF_B];
        c.sst_clr = we & wd[SST_B];
        c.fst_set = we & wd[FST_B];
        c.sa_clr  = we & wd[SA_B];
        return c;
    endfunction

    function automatic csr_view_t build_view(input logic [N_STICKY-1:0] q,
                                             input logic wake,
                                             input logic rxne);
        csr_view_t v;
        v.opr  = q[SL_OUT];
        v.ipr  = 1'b0;
        v.ftf  = 1'b0;
        v.wake = wake;
        v.sst  = q[SL_SST];
        v.fst  = q[SL_FST];
        v.rxne = rxne;
        v.sa   = q[SL_SA];
        return v;
    endfunction

endpackage

// File: rtl/ep0_sticky_bit.sv
module ep0_sticky_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    // Set has priority so that an event is never lost to a clear.
    always_ff @(posedge clk) begin
        if (rst) q_o <= 1'b0;
        else     q_o <= (q_o & ~clr_i) | set_i;
    end

    // Covers R2, R9, R10, R11 and the arming side of R4/R5.
    assert_set_wins_R2: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q_o);
    assert_clear_takes_R5: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !q_o);

endmodule

// File: rtl/ep0_wr_decode.sv
module ep0_wr_decode
    import ep0_csr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ACTIVE_W-1:0] wdata,
    output sw_cmd_t             cmd,
    output logic                flush_pulse
);

    assign cmd = decode_write(wr_en, wdata);

    always_ff @(posedge clk) begin
        if (rst) flush_pulse <= 1'b0;
        else     flush_pulse <= cmd.flush;
    end

    assert_flush_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        (flush_pulse && !$past(wr_en && wdata[FTF_B])) |-> 1'b0);
    assert_flush_follows_write_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[FTF_B]) |=> flush_pulse);

endmodule

// File: rtl/ep0_irq_gen.sv
module ep0_irq_gen (
    input  logic clk,
    input  logic rst,
    input  logic mask_i,
    input  logic out_evt_i,
    input  logic in_done_i,
    output logic irq_o
);

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= mask_i & (out_evt_i | in_done_i);
    end

    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
        !mask_i |=> !irq_o);
    assert_irq_on_out_R6: assert property (@(posedge clk) disable iff (rst)
        (mask_i && out_evt_i) |=> irq_o);

endmodule

// File: rtl/ep0_ctrl_csr.sv
module ep0_ctrl_csr
    import ep0_csr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_out_rcvd,
    input  logic              ev_in_sent,
    input  logic              ev_ctrl_out,
    input  logic              ev_stall_sent,
    input  logic              ev_setup,
    input  logic              st_wakeup_en,
    input  logic              st_rx_nempty,
    input  logic              irq_mask,
    output logic              irq_ep0,
    output logic              data_hold,
    output logic              in_pkt_rdy,
    output logic              flush_strobe,
    output logic              stall_force
);

    localparam int unsigned RSV_W = DATA_W - ACTIVE_W;

    hw_evt_t               evt;
    sw_cmd_t               cmd;
    csr_view_t             view;
    logic [N_STICKY-1:0]   st_set;
    logic [N_STICKY-1:0]   st_clr;
    logic [N_STICKY-1:0]   st_q;
    logic                  in_done;

    assign evt = '{out_rcvd:   ev_out_rcvd,
                   in_sent:    ev_in_sent,
                   ctrl_out:   ev_ctrl_out,
                   stall_sent: ev_stall_sent,
                   setup:      ev_setup};

    ep0_wr_decode u_dec (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (reg_wr_en),
        .wdata       (reg_wdata[ACTIVE_W-1:0]),
        .cmd         (cmd),
        .flush_pulse (flush_strobe)
    );

    // Set and clear sources for each held bit.
    always_comb begin
        st_set         = '0;
        st_clr         = '0;
        st_set[SL_OUT] = evt.out_rcvd;
        st_clr[SL_OUT] = cmd.opr_clr;
        st_set[SL_IN]  = cmd.ipr_set & ~cmd.flush;
        st_clr[SL_IN]  = evt.in_sent | evt.ctrl_out | cmd.flush;
        st_set[SL_SST] = evt.stall_sent;
        st_clr[SL_SST] = cmd.sst_clr;
        st_set[SL_FST] = cmd.fst_set;
        st_clr[SL_FST] = evt.stall_sent;
        st_set[SL_SA]  = evt.setup;
        st_clr[SL_SA]  = cmd.sa_clr;
    end

    for (genvar g = 0; g < N_STICKY; g++) begin : g_bit
        ep0_sticky_bit u_bit (
            .clk   (clk),
            .rst   (rst),
            .set_i (st_set[g]),
            .clr_i (st_clr[g]),
            .q_o   (st_q[g])
        );
    end

    // Only transfer completion or control OUT retire the IN packet loudly.
    assign in_done = st_q[SL_IN] & (evt.in_sent | evt.ctrl_out);

    ep0_irq_gen u_irq (
        .clk       (clk),
        .rst       (rst),
        .mask_i    (irq_mask),
        .out_evt_i (evt.out_rcvd),
        .in_done_i (in_done),
        .irq_o     (irq_ep0)
    );

    assign view        = build_view(st_q, st_wakeup_en, st_rx_nempty);
    assign reg_rdata   = {{RSV_W{1'b0}}, view};
    assign data_hold   = st_q[SL_OUT];
    assign in_pkt_rdy  = st_q[SL_IN];
    assign stall_force = st_q[SL_FST];

    assert_out_seen_R2: assert property (@(posedge clk) disable iff (rst)
        ev_out_rcvd |=> (reg_rdata[OPR_B] && data_hold));
    assert_in_retired_R5: assert property (@(posedge clk) disable iff (rst)
        ((ev_in_sent || ev_ctrl_out) && !(reg_wr_en && reg_wdata[IPR_B])) |=> !in_pkt_rdy);
    assert_flush_silent_R7: assert property (@(posedge clk) disable iff (rst)
        (in_pkt_rdy && reg_wr_en && reg_wdata[FTF_B] && !ev_in_sent && !ev_ctrl_out
         && !ev_out_rcvd) |=> (!irq_ep0 && !in_pkt_rdy));
    assert_in_done_irq_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_mask && in_pkt_rdy && (ev_in_sent || ev_ctrl_out)) |=> irq_ep0);
    assert_stall_handoff_R10: assert property (@(posedge clk) disable iff (rst)
        (ev_stall_sent && !(reg_wr_en && reg_wdata[FST_B])) |=> (reg_rdata[SST_B] && !stall_force));
    assert_setup_kept_R11: assert property (@(posedge clk) disable iff (rst)
        ev_setup |=> reg_rdata[SA_B]);
    assert_ro_wake_R12: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_wdata[WAKE_B] && !st_wakeup_en) |-> !reg_rdata[WAKE_B]);
    assert_ro_rxne_R12: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_wdata[RXNE_B] && !st_rx_nempty) |-> !reg_rdata[RXNE_B]);
    assert_rsv_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && (|reg_wdata[DATA_W-1:ACTIVE_W])) |=> (reg_rdata[DATA_W-1:ACTIVE_W] == '0));

endmodule

// File: tb/test_ep0_ctrl_csr.sv
module test_ep0_ctrl_csr;

    typedef struct packed {
        int         req;
        logic       wr;
        logic [7:0] wd;
        logic [4:0] ev;     // {out_rcvd, in_sent, ctrl_out, stall_sent, setup}
        logic       msk;
        logic [7:0] exp_rd;
        logic       exp_in;
        logic       exp_irq;
        logic       exp_fl;
    } vec_t;

    function automatic vec_t mk(int r, logic w, logic [7:0] d, logic [4:0] e, logic m,
                                logic [7:0] xr, logic xi, logic xq, logic xf);
        vec_t v;
        v.req = r; v.wr = w; v.wd = d; v.ev = e; v.msk = m;
        v.exp_rd = xr; v.exp_in = xi; v.exp_irq = xq; v.exp_fl = xf;
        return v;
    endfunction

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        mk(2,  0, 8'h00, 5'b10000, 1, 8'h01, 0, 1, 0), // R2 OUT event sets bit 0, irq
        mk(3,  0, 8'h00, 5'b00000, 1, 8'h01, 0, 0, 0), // R3 hold persists
        mk(2,  1, 8'h01, 5'b00000, 1, 8'h00, 0, 0, 0), // R2 write-one clears
        mk(4,  1, 8'h02, 5'b00000, 1, 8'h00, 1, 0, 0), // R4 arm, reads zero
        mk(4,  1, 8'h00, 5'b00000, 1, 8'h00, 1, 0, 0), // R4 zero write keeps it
        mk(6,  0, 8'h00, 5'b01000, 1, 8'h00, 0, 1, 0), // R6 sent -> irq
        mk(4,  1, 8'h02, 5'b00000, 1, 8'h00, 1, 0, 0), // R4 re-arm
        mk(7,  1, 8'h04, 5'b00000, 1, 8'h00, 0, 0, 1), // R7 R8 flush silent
        mk(4,  1, 8'h02, 5'b00000, 1, 8'h00, 1, 0, 0), // R4 re-arm
        mk(6,  0, 8'h00, 5'b00100, 1, 8'h00, 0, 1, 0), // R6 ctrl OUT -> irq
        mk(4,  1, 8'h02, 5'b00000, 0, 8'h00, 1, 0, 0), // R4 arm, mask off
        mk(7,  0, 8'h00, 5'b01000, 0, 8'h00, 0, 0, 0), // R7 masked
        mk(10, 1, 8'h20, 5'b00000, 1, 8'h20, 0, 0, 0), // R10 force stall
        mk(9,  0, 8'h00, 5'b00010, 1, 8'h10, 0, 0, 0), // R9 stall sent, fst drops
        mk(9,  1, 8'h10, 5'b00000, 1, 8'h00, 0, 0, 0), // R9 cleared
        mk(11, 0, 8'h00, 5'b00001, 1, 8'h80, 0, 0, 0), // R11 setup
        mk(11, 1, 8'h80, 5'b00001, 1, 8'h80, 0, 0, 0), // R11 event wins
        mk(11, 1, 8'h80, 5'b00000, 1, 8'h00, 0, 0, 0), // R11 cleared
        mk(2,  1, 8'h01, 5'b10000, 1, 8'h01, 0, 1, 0), // R2 event wins
        mk(2,  1, 8'h01, 5'b00000, 1, 8'h00, 0, 0, 0)  // R2 cleared
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_out_rcvd = 0, ev_in_sent = 0, ev_ctrl_out = 0, ev_stall_sent = 0, ev_setup = 0;
    logic        st_wakeup_en = 0, st_rx_nempty = 0, irq_mask = 1;
    logic        irq_ep0, data_hold, in_pkt_rdy, flush_strobe, stall_force;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    ep0_ctrl_csr i_ep0_ctrl_csr (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ev_out_rcvd(ev_out_rcvd), .ev_in_sent(ev_in_sent),
        .ev_ctrl_out(ev_ctrl_out), .ev_stall_sent(ev_stall_sent), .ev_setup(ev_setup),
        .st_wakeup_en(st_wakeup_en), .st_rx_nempty(st_rx_nempty), .irq_mask(irq_mask),
        .irq_ep0(irq_ep0), .data_hold(data_hold), .in_pkt_rdy(in_pkt_rdy),
        .flush_strobe(flush_strobe), .stall_force(stall_force)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus, then sample after the capturing edge.
    task automatic step(logic w, logic [31:0] d, logic [4:0] e, logic m);
        @(negedge clk);
        reg_wr_en = w; reg_wdata = d; irq_mask = m;
        {ev_out_rcvd, ev_in_sent, ev_ctrl_out, ev_stall_sent, ev_setup} = e;
        @(posedge clk);
        #2;
        reg_wr_en = 0; reg_wdata = '0;
        {ev_out_rcvd, ev_in_sent, ev_ctrl_out, ev_stall_sent, ev_setup} = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", "rdata", reg_rdata, 32'h0);
        chk("R1", "outputs", {27'h0, irq_ep0, data_hold, in_pkt_rdy, flush_strobe, stall_force}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            string t;
            t = $sformatf("R%0d", TBL[i].req);
            step(TBL[i].wr, {24'h0, TBL[i].wd}, TBL[i].ev, TBL[i].msk);
            chk(t, $sformatf("vec %0d rdata", i), reg_rdata, {24'h0, TBL[i].exp_rd});
            chk(t, $sformatf("vec %0d in_pkt_rdy", i), in_pkt_rdy, TBL[i].exp_in);
            chk(t, $sformatf("vec %0d irq", i), irq_ep0, TBL[i].exp_irq);
            chk(t, $sformatf("vec %0d flush", i), flush_strobe, TBL[i].exp_fl);
            chk("R3", $sformatf("vec %0d hold", i), data_hold, TBL[i].exp_rd[0]);
            chk("R10", $sformatf("vec %0d stall_force", i), stall_force, TBL[i].exp_rd[5]);
        end

        // R1 reserved bits ignore writes
        step(1, 32'hFFFF_FF00, 5'b0, 1);
        chk("R1", "reserved write", reg_rdata, 32'h0);

        // R12 read-only status, writes ignored
        st_wakeup_en = 1; st_rx_nempty = 0;
        step(1, 32'h48, 5'b0, 1);
        chk("R12", "wake only", reg_rdata, 32'h08);
        st_wakeup_en = 0; st_rx_nempty = 1;
        #1;
        chk("R12", "rx only", reg_rdata, 32'h40);
        st_rx_nempty = 0;

        // R5 arm in same cycle as retirement keeps it armed; irq for retired one
        step(1, 32'h02, 5'b0, 1);
        step(1, 32'h02, 5'b01000, 1);
        chk("R5", "rearm wins", in_pkt_rdy, 1'b1);
        chk("R6", "irq on retire", irq_ep0, 1'b1);
        // R5 arm plus flush in one write leaves it cleared, no irq
        step(1, 32'h06, 5'b0, 1);
        chk("R5", "arm+flush", in_pkt_rdy, 1'b0);
        chk("R7", "no irq on flush", irq_ep0, 1'b0);
        chk("R8", "flush strobe", flush_strobe, 1'b1);
        step(0, 32'h0, 5'b0, 1);
        chk("R8", "flush one cycle", flush_strobe, 1'b0);

        // R10 force-stall write wins over stall-sent event
        step(1, 32'h20, 5'b00010, 1);
        chk("R10", "write wins", reg_rdata, 32'h30);
        step(1, 32'h10, 5'b00010, 1);
        chk("R9", "event wins", reg_rdata, 32'h10);

        // R1 reset clears everything
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #2;
        @(negedge clk) rst = 1'b0;
        #1;
        chk("R1", "re-reset", reg_rdata, 32'h0);
        chk("R1", "stall_force after reset", stall_force, 1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule